// File: doc/BRIEF.md
# I2C Interrupt Vector Prioritizer

This block gathers the event pulses of an I2C controller's protocol engine into a sticky status register. It gates that register with an enable mask and reports the most urgent enabled event as a three-bit vector code. A single level interrupt line stays high while any enabled event is pending.

Software sees three word registers behind a small read/write port: the event status, the enable mask and the vector. An interrupt handler reads the vector again and again until it returns zero. Each read retires the event it reports, so the handler steps through every pending source in priority order. Software can also retire flags by writing ones to the status word.

There is no sequencer; the block has two clocked states, the flag bank and the mask, plus combinational selection. Events and their codes are:

| Event | Status bit | Code |
|---|---|---|
| arbitration lost | 0 | 1 |
| missing acknowledge | 1 | 2 |
| register access ready | 2 | 3 |
| receive data ready | 3 | 4 |
| transmit ready | 4 | 5 |
| stop seen | 5 | 6 |
| addressed as target | 6 | 7 |

Top module: `i2c_irq_vector`

## Requirements
- R1: After reset the status, mask and vector registers all read 0 (with both bus-state inputs low), and `irq` is low.
- R2: A high `evt_set[i]` in a cycle sets status bit i from the next clock edge. Bit i follows the table above, for example bit 0 is arbitration lost and bit 6 is addressed as target.
- R3: Writing the status register (address 0) with a 1 in bit i clears flag i. A 0 in bit i leaves flag i unchanged.
- R4: The vector register (address 2) reads the code of the pending, enabled event with the lowest bit index; that code is the bit index plus 1. It reads 0 when no enabled event is pending.
- R5: A flag whose mask bit is 0 stays visible in the status register, but it never affects the vector or `irq`.
- R6: A vector read that returns a nonzero code clears exactly that event's flag at the end of the read cycle. Repeated reads therefore return each enabled pending code in ascending order, then 0.
- R7: `irq` is high exactly while some status bit 0..6 and its mask bit are both 1.
- R8: When a set pulse and a clear (by status write or by vector read) hit the same flag in the same cycle, the flag ends up set.
- R9: Status bit 12 reflects `bus_busy` and bit 11 reflects `rx_shift_full`. Writes cannot change them, and they never drive the vector or `irq`.
- R10: The mask register (address 1) takes bits 0..6 of a write and reads them back in the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_set | input | 7 | One-cycle event pulses from the protocol engine |
| bus_busy | input | 1 | Bus-busy level, shown at status bit 12 |
| rx_shift_full | input | 1 | Receive-shift-full level, shown at status bit 11 |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a vector read retires an event) |
| reg_addr | input | 2 | 0 status, 1 mask, 2 vector, 3 reads 0 |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
A flag that is stuck or lost shows up as a wrong code on the very next vector read. It also shows up in the zero/nonzero pattern of the drain that follows, and in `irq` one cycle after the pulse or clear. A wrong priority order shows as a permuted sequence of codes when several events are drained at once. A retire that clears the wrong bit shows as a repeated or skipped code within one or two reads. A lost set-versus-clear collision shows as a flag missing from the status readback in the cycle right after the collision.

// File: rtl/i2c_ivec_pkg.sv
package i2c_ivec_pkg;

    // register selector on the small access port
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_VECTOR = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int unsigned EVT_COUNT   = 7;
    localparam int unsigned WORD_W      = 16;
    localparam int unsigned BUSY_POS    = 12;
    localparam int unsigned SHIFT_FULL_POS = 11;

endpackage

// File: rtl/ivec_flag_bank.sv
module ivec_flag_bank #(
    parameter int unsigned N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);

    logic [N-1:0] flags_q;

    // set has priority over clear, so a colliding event survives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= (flags_q & ~clr_i) | set_i;
        end
    end

    assign flags_o = flags_q;

    // R2
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((flags_q & $past(set_i)) == $past(set_i)));

    // R3
    clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((flags_q & $past(clr_i & ~set_i)) == '0));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & clr_i) != '0) |=> ((flags_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));

endmodule

// File: rtl/ivec_prio_enc.sv
module ivec_prio_enc #(
    parameter int unsigned N      = 7,
    parameter int unsigned CODE_W = $clog2(N + 1)
) (
    input  logic [N-1:0]      req_i,
    output logic [CODE_W-1:0] code_o,
    output logic              any_o
);

    // scan from the top down so the lowest index is written last and wins
    always_comb begin
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                code_o = CODE_W'(i + 1);
            end
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/i2c_irq_vector.sv
module i2c_irq_vector
    import i2c_ivec_pkg::*;
#(
    parameter int unsigned NUM_EVT   = EVT_COUNT,
    parameter int unsigned DATA_W    = WORD_W,
    parameter int unsigned BUSY_BIT  = BUSY_POS,
    parameter int unsigned SFULL_BIT = SHIFT_FULL_POS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EVT-1:0] evt_set,
    input  logic              bus_busy,
    input  logic              rx_shift_full,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam int unsigned CODE_W = $clog2(NUM_EVT + 1);

    reg_sel_e            sel;
    logic [NUM_EVT-1:0]  flags;
    logic [NUM_EVT-1:0]  mask_q;
    logic [NUM_EVT-1:0]  live;
    logic [NUM_EVT-1:0]  wr_clr;
    logic [NUM_EVT-1:0]  vec_clr;
    logic [NUM_EVT-1:0]  clr_all;
    logic [CODE_W-1:0]   vec_code;
    logic                vec_any;
    logic                wr_stat;
    logic                wr_mask;
    logic                rd_vec;
    logic                wdata_unused;

    assign sel     = reg_sel_e'(reg_addr);
    assign wr_stat = reg_wr && (sel == SEL_STATUS);
    assign wr_mask = reg_wr && (sel == SEL_MASK);
    assign rd_vec  = reg_rd && (sel == SEL_VECTOR);
    assign wdata_unused = ^reg_wdata[DATA_W-1:NUM_EVT];

    // enable mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_mask) begin
            mask_q <= reg_wdata[NUM_EVT-1:0];
        end
    end

    // clear sources: write-one-to-clear and retire-on-vector-read
    assign wr_clr = wr_stat ? reg_wdata[NUM_EVT-1:0] : '0;

    always_comb begin
        vec_clr = '0;
        if (rd_vec && vec_any) begin
            vec_clr[vec_code - CODE_W'(1)] = 1'b1;
        end
    end

    assign clr_all = wr_clr | vec_clr;

    ivec_flag_bank #(.N(NUM_EVT)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt_set),
        .clr_i   (clr_all),
        .flags_o (flags)
    );

    assign live = flags & mask_q;

    ivec_prio_enc #(.N(NUM_EVT), .CODE_W(CODE_W)) u_enc (
        .req_i  (live),
        .code_o (vec_code),
        .any_o  (vec_any)
    );

    assign irq = vec_any;

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_STATUS: begin
                reg_rdata[NUM_EVT-1:0] = flags;
                reg_rdata[BUSY_BIT]    = bus_busy;
                reg_rdata[SFULL_BIT]   = rx_shift_full;
            end
            SEL_MASK:   reg_rdata[NUM_EVT-1:0] = mask_q;
            SEL_VECTOR: reg_rdata[CODE_W-1:0]  = vec_code;
            SEL_NONE:   reg_rdata = '0;
        endcase
    end

    // R7
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((flags & mask_q) != '0));

    // R4
    vector_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code != '0) |-> (live[vec_code - CODE_W'(1)] &&
            ((live & ((NUM_EVT'(1) << (vec_code - CODE_W'(1))) - NUM_EVT'(1))) == '0)));

    // R4
    vector_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_code == '0) == (live == '0));

    // R6
    retire_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_vec && vec_any && !wr_stat && (evt_set == '0))
            |=> ($countones(flags) + 1 == $countones($past(flags))));

    // R10
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_q == $past(reg_wdata[NUM_EVT-1:0])));

endmodule

// File: tb/i2c_irq_vector_tb.sv
module i2c_irq_vector_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt_set = '0;
    logic        bus_busy = 1'b0;
    logic        rx_shift_full = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [1:0]  addr;
        logic [15:0] data;
        string       tag;
    } exp_t;

    exp_t sb_q[$];
    exp_t cur;

    always #2.5 clk = ~clk;   // 200 MHz

    i2c_irq_vector u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_set       (evt_set),
        .bus_busy      (bus_busy),
        .rx_shift_full (rx_shift_full),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .irq           (irq)
    );

    // monitor: compares each read against the scoreboard head
    always @(negedge clk) begin
        if (reg_rd) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: actual %h expected none", reg_rdata);
            end else begin
                cur = sb_q.pop_front();
                if (reg_rdata !== cur.data) begin
                    errors++;
                    $display("FAIL %s addr %0d: actual %h expected %h",
                             cur.tag, cur.addr, reg_rdata, cur.data);
                end
            end
        end
    end

    // driver: one access cycle, optionally with a simultaneous event pulse
    task automatic bus_op(input logic wr, input logic rd, input logic [1:0] addr,
                          input logic [15:0] wdata, input logic [6:0] set,
                          input logic [15:0] exp, input string tag);
        exp_t e;
        @(posedge clk); #1;
        reg_wr    = wr;
        reg_rd    = rd;
        reg_addr  = addr;
        reg_wdata = wdata;
        evt_set   = set;
        if (rd) begin
            e.addr = addr; e.data = exp; e.tag = tag;
            sb_q.push_back(e);
        end
        @(posedge clk); #1;
        reg_wr = 1'b0; reg_rd = 1'b0; evt_set = '0; reg_wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] addr, input logic [15:0] exp, input string tag);
        bus_op(1'b0, 1'b1, addr, 16'h0, 7'h0, exp, tag);
    endtask

    task automatic wr_reg(input logic [1:0] addr, input logic [15:0] data);
        bus_op(1'b1, 1'b0, addr, data, 7'h0, 16'h0, "");
    endtask

    task automatic pulse(input logic [6:0] set);
        bus_op(1'b0, 1'b0, 2'd0, 16'h0, set, 16'h0, "");
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s irq: actual %b expected %b", tag, irq, exp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd_reg(2'd0, 16'h0000, "R1 status");
        rd_reg(2'd1, 16'h0000, "R1 mask");
        rd_reg(2'd2, 16'h0000, "R1 vector");
        chk_irq(1'b0, "R1");

        // R2 all events land in their bits; R5 masked off
        pulse(7'h7F);
        rd_reg(2'd0, 16'h007F, "R2 status layout");
        rd_reg(2'd2, 16'h0000, "R5 vector masked");
        chk_irq(1'b0, "R5");

        // R10 mask readback, R7 irq rises
        wr_reg(2'd1, 16'hFF7F);
        rd_reg(2'd1, 16'h007F, "R10 mask");
        chk_irq(1'b1, "R7 enabled pending");

        // R4 R6 drain in ascending order
        for (int k = 1; k <= 7; k++) begin
            rd_reg(2'd2, 16'(k), "R6 drain");
        end
        rd_reg(2'd2, 16'h0000, "R4 empty");
        rd_reg(2'd0, 16'h0000, "R6 status drained");
        chk_irq(1'b0, "R7 none pending");

        // R4 priority with a later, more urgent arrival
        pulse(7'h28);
        rd_reg(2'd2, 16'h0004, "R4 receive first");
        pulse(7'h01);
        rd_reg(2'd2, 16'h0001, "R4 arbitration first");
        rd_reg(2'd2, 16'h0006, "R4 stop next");
        rd_reg(2'd2, 16'h0000, "R4 empty again");

        // R5 partial mask
        wr_reg(2'd1, 16'h0010);
        pulse(7'h14);
        rd_reg(2'd2, 16'h0005, "R5 transmit only");
        rd_reg(2'd2, 16'h0000, "R5 masked not reported");
        rd_reg(2'd0, 16'h0004, "R5 masked still pending");
        chk_irq(1'b0, "R5 irq masked");

        // R3 write-one-to-clear
        wr_reg(2'd0, 16'h0000);
        rd_reg(2'd0, 16'h0004, "R3 zero write");
        wr_reg(2'd0, 16'h0004);
        rd_reg(2'd0, 16'h0000, "R3 one write");
        pulse(7'h03);
        wr_reg(2'd0, 16'h0001);
        rd_reg(2'd0, 16'h0002, "R3 selective");

        // R8 set wins over status-write clear
        bus_op(1'b1, 1'b0, 2'd0, 16'h0002, 7'h02, 16'h0, "");
        rd_reg(2'd0, 16'h0002, "R8 write collision");
        // R8 set wins over vector-read retire
        wr_reg(2'd1, 16'h007F);
        bus_op(1'b0, 1'b1, 2'd2, 16'h0, 7'h02, 16'h0002, "R8 read collision vector");
        rd_reg(2'd0, 16'h0002, "R8 read collision status");
        rd_reg(2'd2, 16'h0002, "R6 retire");
        rd_reg(2'd2, 16'h0000, "R6 empty");

        // R9 bus-state bits
        @(posedge clk); #1;
        bus_busy = 1'b1; rx_shift_full = 1'b1;
        rd_reg(2'd0, 16'h1800, "R9 mirror");
        rd_reg(2'd2, 16'h0000, "R9 not a source");
        chk_irq(1'b0, "R9 irq");
        wr_reg(2'd0, 16'hFFFF);
        rd_reg(2'd0, 16'h1800, "R9 write ignored");
        rd_reg(2'd3, 16'h0000, "R9 spare address");

        repeat (2) @(posedge clk);
        if (sb_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard leftover: actual %0d expected 0", sb_q.size());
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule